// File: doc/BRIEF.md
# Host Bus Select and Read-Strobe Front End

This block sits between a host processor bus and the register file of a serial communications controller. It turns the raw bus signals into a few clean, registered controls: whether this device is selected, which of its eight registers the host is addressing, when a read has started, and whether an external bus transceiver should be driven. The register index and chip selects can follow the bus directly while the address strobe is low, or be frozen by raising it. Some of the three chip selects and two read strobes are active-high and some are active-low.

All inputs are sampled on the system clock. A rising transition of the address strobe is seen as a change between two samples. The capture takes effect on the same clock edge that sees the strobe high. A qualified read produces a one-cycle pulse on its first cycle, so clear-on-read logic further on acts once per access. Small stub registers stand in for the register file so that the read path and its single side effect, clearing a sticky status flag, can be observed.

Top module: `bus_sel_front`

## Requirements
- R1: While `rst_n` is sampled low at a clock edge, after that edge `sel` is 0, `reg_idx` is 0, `rd_pulse` is 0, `drv_dis` is 1 and `rd_data` is 0.
- R2: At a clock edge where `as_n` is sampled low, `reg_idx` takes the sampled `reg_addr` and `sel` takes the sampled chip-select decode, both visible right after that edge.
- R3: At the first edge where `as_n` is sampled high after being sampled low, the values sampled at that same edge are captured. At later edges where `as_n` stays high, `sel` and `reg_idx` hold, whatever the address and chip selects do.
- R4: The chip-select decode is true only when `cs_in[0]`=1, `cs_in[1]`=1 and `cs_in[2]`=0. Any other combination leaves the device unselected.
- R5: A read request is `rd_in[0]`=1 or `rd_in[1]`=0, and either one alone is enough. The request is sampled at the same edge as the select. A qualified read is a sampled request while `sel` is 1.
- R6: `drv_dis` is 0 exactly while a qualified read is in progress, and 1 otherwise.
- R7: `rd_pulse` is 1 for exactly the first cycle of a qualified read. It does not pulse again until the qualified read has ended.
- R8: During a qualified read, `rd_data` shows the stub register at `reg_idx`. Stub register k (k≠6) holds ((k·29) XOR 165) mod 256. Whenever no qualified read is in progress, `rd_data` is 0.
- R9: Stub register 6 reads as {7'b0, flag}. The flag is set at an edge where `evt_in` is sampled 1. It is cleared at the edge that ends a cycle in which `rd_pulse` was 1 with `reg_idx`=6, and setting wins over clearing. A read while unselected does not clear it.
- R10: Reset clears the latched state. If `as_n` stays high after reset, nothing is selected until `as_n` is sampled low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low master reset |
| as_n | input | 1 | Address strobe: low passes select inputs through, rising edge freezes them |
| reg_addr | input | 3 | Register address from the host |
| cs_in | input | 3 | Chip selects; bits 0 and 1 active-high, bit 2 active-low |
| rd_in | input | 2 | Read strobes; bit 0 active-high, bit 1 active-low |
| evt_in | input | 1 | Sets the sticky status flag in stub register 6 |
| sel | output | 1 | Registered device-selected flag |
| reg_idx | output | 3 | Latched register index |
| rd_pulse | output | 1 | One-cycle pulse at the start of a qualified read |
| drv_dis | output | 1 | High unless a qualified read is in progress |
| rd_data | output | 8 | Read data from the stub registers, 0 when not reading |

## Verification
The bench goes after the strobe edge itself. A capture taken one edge late would freeze the address that follows the strobe rather than the one present at the rise, and a latch that ignored the hold would let `reg_idx` drift while the strobe is high. Each chip select is made inactive on its own, and each read strobe is used alone, so that a flipped polarity shows up as a wrong `sel` or a missing read. Reads that last several cycles catch a pulse that repeats, and reads of the status register while unselected or just after reset catch a flag cleared without a real access or a latch that keeps its select through reset.

// File: rtl/bsel_pkg.sv
// Package: shared constants, types and the stub register contents for the
// host bus select front end. Assumes an 8-bit data path.
package bsel_pkg;

    localparam int unsigned BSEL_ADDR_W = 3;
    localparam int unsigned BSEL_DATA_W = 8;

    // Which way the select latch moves on a given clock edge.
    typedef enum logic [1:0] {
        SM_HOLD    = 2'd0,
        SM_PASS    = 2'd1,
        SM_CAPTURE = 2'd2
    } strobe_mode_e;

    // Fixed content of a plain stub register, derived from its index.
    function automatic logic [BSEL_DATA_W-1:0] stub_value(input int unsigned k);
        int unsigned v;
        v = ((k * 29) ^ 165) & 255;
        return BSEL_DATA_W'(v);
    endfunction

endpackage

// File: rtl/bsel_latch.sv
// Module: address strobe latch and chip-select decode.
// The address and decoded select follow the inputs while the strobe is
// low. On the edge that first sees the strobe high, they are captured from
// that same sample. They then hold while the strobe stays high.
// Assumes all inputs are already synchronous to clk.
module bsel_latch #(
    parameter int unsigned        ADDR_W = 3,
    parameter int unsigned        NUM_CS = 3,
    parameter logic [NUM_CS-1:0]  CS_POL = 3'b011   // 1 = active-high
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              as_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [NUM_CS-1:0] cs_i,
    output logic              sel_o,
    output logic [ADDR_W-1:0] idx_o
);
    import bsel_pkg::*;

    logic [NUM_CS-1:0] cs_act;
    logic              cs_all;
    logic              as_prev_q;
    strobe_mode_e      mode;

    // Normalise each chip select to active-high as its polarity dictates.
    for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
        if (CS_POL[i]) begin : g_hi
            assign cs_act[i] = cs_i[i];
        end else begin : g_lo
            assign cs_act[i] = ~cs_i[i];
        end
    end

    assign cs_all = &cs_act;

    // Pick pass-through, same-edge capture or hold for this edge.
    always_comb begin
        if (!as_n)          mode = SM_PASS;
        else if (!as_prev_q) mode = SM_CAPTURE;
        else                mode = SM_HOLD;
    end

    // Remember the previous strobe sample; reset counts as "high".
    always_ff @(posedge clk) begin
        if (!rst_n) as_prev_q <= 1'b1;
        else        as_prev_q <= as_n;
    end

    // Update or hold the latched select and index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_o <= 1'b0;
            idx_o <= '0;
        end else if (mode != SM_HOLD) begin
            sel_o <= cs_all;
            idx_o <= addr_i;
        end
    end

    AST_HOLD_WHILE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && as_n && as_prev_q) |=> ($stable(sel_o) && $stable(idx_o))); // R3

    AST_PASS_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !as_n) |=> (idx_o == $past(addr_i))); // R2

endmodule

// File: rtl/bsel_rdqual.sv
// Module: read strobe qualification.
// Normalises the read strobes, registers the request and ANDs it with the
// registered select. Produces a first-cycle pulse and the transceiver
// disable. Assumes sel_i is already registered on the same clock.
module bsel_rdqual #(
    parameter int unsigned        NUM_RD = 2,
    parameter logic [NUM_RD-1:0]  RD_POL = 2'b01    // 1 = active-high
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_RD-1:0] rd_i,
    input  logic              sel_i,
    output logic              qual_o,
    output logic              pulse_o,
    output logic              drv_dis_o
);
    logic [NUM_RD-1:0] rd_act;
    logic              req_q;
    logic              qual_d_q;

    // Normalise each read strobe to active-high as its polarity dictates.
    for (genvar i = 0; i < NUM_RD; i++) begin : g_rd
        if (RD_POL[i]) begin : g_hi
            assign rd_act[i] = rd_i[i];
        end else begin : g_lo
            assign rd_act[i] = ~rd_i[i];
        end
    end

    // Sample the request on the same edge as the select latch.
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= 1'b0;
        else        req_q <= |rd_act;
    end

    assign qual_o = sel_i & req_q;

    // Delay the qualified read by one cycle for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) qual_d_q <= 1'b0;
        else        qual_d_q <= qual_o;
    end

    assign pulse_o   = qual_o & ~qual_d_q;
    assign drv_dis_o = ~qual_o;

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |=> !pulse_o); // R7

    AST_PULSE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |-> !drv_dis_o); // R6

endmodule

// File: rtl/bsel_stubs.sv
// Module: stub register file for exercising the read path.
// Plain registers return a fixed pattern. One status register carries a
// sticky flag that a qualified read pulse clears. Assumes pulse_i lasts one
// cycle per access.
module bsel_stubs #(
    parameter int unsigned ADDR_W     = 3,
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned STATUS_IDX = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] idx_i,
    input  logic              qual_i,
    input  logic              pulse_i,
    input  logic              evt_i,
    output logic [DATA_W-1:0] data_o
);
    import bsel_pkg::*;

    localparam int unsigned NUM_REGS = 1 << ADDR_W;

    logic [DATA_W-1:0] regs [NUM_REGS];
    logic              flag_q;
    logic              clr;

    assign clr = pulse_i && (idx_i == ADDR_W'(STATUS_IDX));

    // Sticky status flag: set has priority over clear-on-read.
    always_ff @(posedge clk) begin
        if (!rst_n)     flag_q <= 1'b0;
        else if (evt_i) flag_q <= 1'b1;
        else if (clr)   flag_q <= 1'b0;
    end

    // Build each register's read value.
    for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
        if (k == STATUS_IDX) begin : g_status
            assign regs[k] = {{(DATA_W-1){1'b0}}, flag_q};
        end else begin : g_plain
            assign regs[k] = stub_value(k);
        end
    end

    // Return data only during a qualified read.
    always_comb begin
        data_o = qual_i ? regs[idx_i] : '0;
    end

    AST_CLEAR_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $fell(flag_q)) |-> $past(clr)); // R9

endmodule

// File: rtl/bus_sel_front.sv
// Module: host bus select and read-strobe front end (top).
// Chains the strobe latch, read qualifier and stub registers. Assumes the
// bus inputs are synchronous to clk and rst_n is a synchronous master reset.
module bus_sel_front #(
    parameter int unsigned ADDR_W     = bsel_pkg::BSEL_ADDR_W,
    parameter int unsigned DATA_W     = bsel_pkg::BSEL_DATA_W,
    parameter int unsigned NUM_CS     = 3,
    parameter int unsigned NUM_RD     = 2,
    parameter int unsigned STATUS_IDX = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              as_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [NUM_CS-1:0] cs_in,
    input  logic [NUM_RD-1:0] rd_in,
    input  logic              evt_in,
    output logic              sel,
    output logic [ADDR_W-1:0] reg_idx,
    output logic              rd_pulse,
    output logic              drv_dis,
    output logic [DATA_W-1:0] rd_data
);
    localparam logic [NUM_CS-1:0] CS_POL = NUM_CS'(3'b011);
    localparam logic [NUM_RD-1:0] RD_POL = NUM_RD'(2'b01);

    logic qual;

    bsel_latch #(
        .ADDR_W (ADDR_W),
        .NUM_CS (NUM_CS),
        .CS_POL (CS_POL)
    ) u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .as_n   (as_n),
        .addr_i (reg_addr),
        .cs_i   (cs_in),
        .sel_o  (sel),
        .idx_o  (reg_idx)
    );

    bsel_rdqual #(
        .NUM_RD (NUM_RD),
        .RD_POL (RD_POL)
    ) u_rdqual (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_i      (rd_in),
        .sel_i     (sel),
        .qual_o    (qual),
        .pulse_o   (rd_pulse),
        .drv_dis_o (drv_dis)
    );

    bsel_stubs #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .STATUS_IDX (STATUS_IDX)
    ) u_stubs (
        .clk     (clk),
        .rst_n   (rst_n),
        .idx_i   (reg_idx),
        .qual_i  (qual),
        .pulse_i (rd_pulse),
        .evt_i   (evt_in),
        .data_o  (rd_data)
    );

    AST_UNSEL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |-> (rd_data == '0 && drv_dis)); // R8

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (!sel && reg_idx == '0)); // R1

endmodule

// File: tb/bus_sel_front_bench.sv
// Scoreboard bench: the driver applies one input set per cycle and pushes the
// expected outputs; the monitor pops and compares after each rising edge.
module bus_sel_front_bench;

    typedef struct {
        logic       sel;
        logic [2:0] idx;
        logic       pulse;
        logic       drv;
        logic [7:0] data;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       as_n = 1'b1;
    logic [2:0] reg_addr = 3'd0;
    logic [2:0] cs_in = 3'b100;
    logic [1:0] rd_in = 2'b10;
    logic       evt_in = 1'b0;
    logic       sel;
    logic [2:0] reg_idx;
    logic       rd_pulse;
    logic       drv_dis;
    logic [7:0] rd_data;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    exp_t q[$];

    // Reference state built from the requirements.
    logic       m_as_prev = 1'b1;
    logic       m_sel = 1'b0;
    logic [2:0] m_idx = 3'd0;
    logic       m_req = 1'b0;
    logic       m_quald = 1'b0;
    logic       m_flag = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    bus_sel_front u_bus_sel_front (
        .clk      (clk),
        .rst_n    (rst_n),
        .as_n     (as_n),
        .reg_addr (reg_addr),
        .cs_in    (cs_in),
        .rd_in    (rd_in),
        .evt_in   (evt_in),
        .sel      (sel),
        .reg_idx  (reg_idx),
        .rd_pulse (rd_pulse),
        .drv_dis  (drv_dis),
        .rd_data  (rd_data)
    );

    function automatic logic [7:0] plain_val(input int k);
        return 8'(((k * 29) ^ 165) & 255);
    endfunction

    // Drive one cycle of inputs and push the outputs expected after the edge.
    task automatic cyc(input logic rn, input logic a, input logic [2:0] ad,
                       input logic [2:0] cs, input logic [1:0] rd,
                       input logic ev, input string tag);
        exp_t e;
        logic pulse_pre, qual;
        @(negedge clk);
        rst_n = rn; as_n = a; reg_addr = ad; cs_in = cs; rd_in = rd; evt_in = ev;
        if (!rn) begin
            m_as_prev = 1'b1; m_sel = 1'b0; m_idx = 3'd0;
            m_req = 1'b0; m_quald = 1'b0; m_flag = 1'b0;
        end else begin
            pulse_pre = m_sel & m_req & ~m_quald;
            if (ev) m_flag = 1'b1;
            else if (pulse_pre && m_idx == 3'd6) m_flag = 1'b0;
            m_quald = m_sel & m_req;
            if (!a || !m_as_prev) begin
                m_sel = cs[0] & cs[1] & ~cs[2];
                m_idx = ad;
            end
            m_as_prev = a;
            m_req = rd[0] | ~rd[1];
        end
        qual = m_sel & m_req;
        e.sel = m_sel;
        e.idx = m_idx;
        e.pulse = qual & ~m_quald;
        e.drv = ~qual;
        e.data = !qual ? 8'h00 : (m_idx == 3'd6 ? {7'b0, m_flag} : plain_val(int'(m_idx)));
        e.tag = tag;
        q.push_back(e);
    endtask

    // Monitor: compare one expected item after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (sel !== e.sel || reg_idx !== e.idx || rd_pulse !== e.pulse ||
                    drv_dis !== e.drv || rd_data !== e.data) begin
                    failures++;
                    $display("FAIL %s: got sel=%b idx=%0d pulse=%b drv_dis=%b data=%h exp sel=%b idx=%0d pulse=%b drv_dis=%b data=%h",
                             e.tag, sel, reg_idx, rd_pulse, drv_dis, rd_data,
                             e.sel, e.idx, e.pulse, e.drv, e.data);
                end
            end
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        cyc(0, 1, 3'd5, 3'b011, 2'b11, 0, "R1");
        cyc(0, 1, 3'd5, 3'b011, 2'b11, 0, "R1");
        // R10: strobe high after reset keeps nothing selected
        cyc(1, 1, 3'd3, 3'b011, 2'b10, 0, "R10");
        cyc(1, 1, 3'd4, 3'b011, 2'b10, 0, "R10");
        // R2 and R4: pass-through with a valid select
        cyc(1, 0, 3'd2, 3'b011, 2'b10, 0, "R2");
        cyc(1, 0, 3'd5, 3'b011, 2'b10, 0, "R2");
        // R4: each chip select inactive on its own
        cyc(1, 0, 3'd1, 3'b010, 2'b10, 0, "R4");
        cyc(1, 0, 3'd1, 3'b001, 2'b10, 0, "R4");
        cyc(1, 0, 3'd1, 3'b111, 2'b10, 0, "R4");
        cyc(1, 0, 3'd1, 3'b011, 2'b10, 0, "R4");
        // R3: capture at the rising strobe edge, then hold
        cyc(1, 0, 3'd4, 3'b011, 2'b10, 0, "R3");
        cyc(1, 1, 3'd1, 3'b011, 2'b10, 0, "R3");
        cyc(1, 1, 3'd7, 3'b000, 2'b10, 0, "R3");
        cyc(1, 1, 3'd2, 3'b100, 2'b10, 0, "R3");
        // R5, R6, R7, R8: read of index 1 with the active-high strobe
        cyc(1, 1, 3'd0, 3'b000, 2'b11, 0, "R7");
        cyc(1, 1, 3'd0, 3'b000, 2'b11, 0, "R7");
        cyc(1, 1, 3'd0, 3'b000, 2'b11, 0, "R6");
        cyc(1, 1, 3'd0, 3'b000, 2'b10, 0, "R6");
        // R5: active-low strobe alone, index 3 via pass-through
        cyc(1, 0, 3'd3, 3'b011, 2'b10, 0, "R5");
        cyc(1, 0, 3'd3, 3'b011, 2'b00, 0, "R5");
        cyc(1, 0, 3'd3, 3'b011, 2'b00, 0, "R8");
        cyc(1, 0, 3'd3, 3'b011, 2'b10, 0, "R5");
        // R8: read while unselected returns zero
        cyc(1, 0, 3'd3, 3'b111, 2'b11, 0, "R8");
        cyc(1, 0, 3'd3, 3'b111, 2'b10, 0, "R8");
        // R9: set the flag, read unselected, then read selected twice
        cyc(1, 0, 3'd6, 3'b111, 2'b10, 1, "R9");
        cyc(1, 0, 3'd6, 3'b111, 2'b11, 0, "R9");
        cyc(1, 0, 3'd6, 3'b111, 2'b10, 0, "R9");
        cyc(1, 0, 3'd6, 3'b011, 2'b10, 0, "R9");
        cyc(1, 0, 3'd6, 3'b011, 2'b11, 0, "R9");
        cyc(1, 0, 3'd6, 3'b011, 2'b11, 0, "R9");
        cyc(1, 0, 3'd6, 3'b011, 2'b10, 0, "R9");
        cyc(1, 0, 3'd6, 3'b011, 2'b11, 0, "R9");
        cyc(1, 0, 3'd6, 3'b011, 2'b10, 0, "R9");
        // R9: set wins over clear in the same cycle
        cyc(1, 0, 3'd6, 3'b011, 2'b11, 1, "R9");
        cyc(1, 0, 3'd6, 3'b011, 2'b11, 1, "R9");
        cyc(1, 0, 3'd6, 3'b011, 2'b10, 0, "R9");
        // R8: walk all plain registers
        for (int k = 0; k < 8; k++) begin
            cyc(1, 0, 3'(k), 3'b011, 2'b10, 0, "R8");
            cyc(1, 0, 3'(k), 3'b011, 2'b11, 0, "R8");
        end
        // R10: reset mid-read clears everything
        cyc(0, 1, 3'd2, 3'b011, 2'b11, 0, "R10");
        cyc(1, 1, 3'd2, 3'b011, 2'b11, 0, "R10");
        cyc(1, 0, 3'd2, 3'b011, 2'b11, 0, "R10");
        cyc(1, 0, 3'd2, 3'b011, 2'b10, 0, "R10");
        repeat (3) @(posedge clk);
        #2;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule